// File: doc/BRIEF.md
# Configuration Command and Status Port

This block is a small command window inside a system-control register space. Software writes a parameter word into a data register and then a command word into a control register. Each command write finishes in the same cycle. The block records completion in a two-bit status register. Two fixed command codes are decoded into one-cycle request pulses, one for system shutdown and one for system reboot. Any other code sets the error bit in the status register as well. Software can read the status register and rewrite it to clear it.

The window exists only on one board variant, chosen by the `PORT_EN` parameter. When the port is absent, every access to its offsets is answered as a bad register. Any access that does not hit one of the three offsets exactly is also answered as a bad register. Each access is a one-cycle request. Exactly one response follows it, registered, in the next cycle.

Top module: `cfgport_top`

## Requirements
- R1: After reset the data, control and status registers read 0, `rsp_valid`, `rsp_err`, `shutdown_req` and `reboot_req` are 0, and reads of the three registers return 0.
- R2: With the port present, the data register at byte offset 0xA0 stores all 32 written bits and returns them on a later read.
- R3: A write to the control register at offset 0xA4 stores the written word with bits 19 and 18 forced to 0, and reads return the stored value.
- R4: Every control write sets status bit 0 (done) to 1 from the next cycle. A status read at 0xA8 returns the two status bits in bits 1:0, with bits 31:2 zero.
- R5: When the stored control value equals 0xC0800000, `shutdown_req` is high for exactly the one cycle after the write, and `reboot_req` stays low. This includes written words that become that value only after bits 19:18 are cleared.
- R6: When the stored control value equals 0xC0900000, `reboot_req` is high for exactly the one cycle after the write, and `shutdown_req` stays low. The two requests are never high together.
- R7: Any other stored control value also sets status bit 1 (error), so the status reads 3, and neither request pulses.
- R8: A write to the status register stores only data bits 1:0 and discards the upper bits. Writing 0 clears both done and error.
- R9: With the port present, an access to any address other than exactly 0xA0, 0xA4 or 0xA8 gets an error response with read data 0 and changes no register.
- R10: With the port absent, every access, including the three offsets, gets an error response with read data 0, and no request ever pulses.
- R11: Every access cycle (`acc_valid` high) is followed in the next cycle by exactly one cycle of `rsp_valid`. Write responses carry read data 0, and `rsp_valid` is low after cycles without an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the access |
| rsp_rdata | output | 32 | Read data; 0 for writes and errors |
| rsp_err | output | 1 | Bad-register response |
| shutdown_req | output | 1 | One-cycle system shutdown request |
| reboot_req | output | 1 | One-cycle system reboot request |

## Verification
The bench builds two copies side by side on the same stimulus. One uses the default `PORT_EN = 1` and the other uses `PORT_EN = 0`, so both the live register window and the absent-port error path (R10) can be reached in one run. The offsets and command codes are left at their defaults. This lets random traffic that mixes the three registers, the two command codes with and without bits 19:18 set, and stray addresses hit every decode branch and the status overwrite ordering.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  parameter int unsigned WORD_W = 32;
  parameter int unsigned STAT_W = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STAT_W-1:0] stat_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    CMD_OTHER    = 2'd0,
    CMD_SHUTDOWN = 2'd1,
    CMD_REBOOT   = 2'd2
  } cmd_kind_e;

  // Clear a field of width w starting at bit lo
  function automatic word_t strip_field(input word_t v, input int unsigned lo,
                                        input int unsigned w);
    word_t r;
    r = v;
    for (int unsigned i = 0; i < WORD_W; i++) begin
      if (i >= lo && i < lo + w) r[i] = 1'b0;
    end
    return r;
  endfunction

  // Status after a command write: done always, error when unknown
  function automatic stat_t status_after(input cmd_kind_e k);
    stat_t s;
    s = '0;
    s[0] = 1'b1;
    if (STAT_W > 1) s[STAT_W-1] = (k == CMD_OTHER);
    return s;
  endfunction

  function automatic word_t widen_status(input stat_t s);
    word_t r;
    r = '0;
    r[STAT_W-1:0] = s;
    return r;
  endfunction
endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter bit          PORT_EN  = 1'b1,
  parameter logic [ADDR_W-1:0] OFS_DATA = 12'h0A0,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h0A4,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h0A8
) (
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output cfg_sel_e          sel,
  output logic              bad,
  output logic              wr_data_hit,
  output logic              wr_ctrl_hit,
  output logic              wr_stat_hit
);
  localparam int unsigned NREG = 3;
  localparam logic [ADDR_W-1:0] OFS_TAB [NREG] = '{OFS_DATA, OFS_CTRL, OFS_STAT};

  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign hit[g] = PORT_EN && (acc_addr == OFS_TAB[g]);
  end

  always_comb begin
    sel = SEL_NONE;
    if (hit[0])      sel = SEL_DATA;
    else if (hit[1]) sel = SEL_CTRL;
    else if (hit[2]) sel = SEL_STAT;
  end

  assign bad         = acc_valid && (sel == SEL_NONE);
  assign wr_data_hit = acc_valid && acc_write && (sel == SEL_DATA);
  assign wr_ctrl_hit = acc_valid && acc_write && (sel == SEL_CTRL);
  assign wr_stat_hit = acc_valid && acc_write && (sel == SEL_STAT);
endmodule

// File: rtl/cfgport_cmd.sv
module cfgport_cmd
  import cfgport_pkg::*;
#(
  parameter int unsigned MASK_LO = 18,
  parameter int unsigned MASK_W  = 2,
  parameter word_t       CODE_SHUTDOWN = 32'hC080_0000,
  parameter word_t       CODE_REBOOT   = 32'hC090_0000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_data_hit,
  input  logic  wr_ctrl_hit,
  input  logic  wr_stat_hit,
  input  word_t wdata,
  output word_t data_q,
  output word_t ctrl_q,
  output stat_t stat_q,
  output logic  cmd_off_hit,
  output logic  cmd_rbt_hit,
  output logic  shutdown_req,
  output logic  reboot_req
);
  word_t     ctrl_next;
  cmd_kind_e kind;

  assign ctrl_next   = strip_field(wdata, MASK_LO, MASK_W);
  assign cmd_off_hit = (ctrl_next == CODE_SHUTDOWN);
  assign cmd_rbt_hit = (ctrl_next == CODE_REBOOT);

  always_comb begin
    kind = CMD_OTHER;
    if (cmd_off_hit)      kind = CMD_SHUTDOWN;
    else if (cmd_rbt_hit) kind = CMD_REBOOT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q       <= '0;
      ctrl_q       <= '0;
      stat_q       <= '0;
      shutdown_req <= 1'b0;
      reboot_req   <= 1'b0;
    end else begin
      shutdown_req <= wr_ctrl_hit && (kind == CMD_SHUTDOWN);
      reboot_req   <= wr_ctrl_hit && (kind == CMD_REBOOT);
      if (wr_data_hit) data_q <= wdata;
      if (wr_ctrl_hit) begin
        ctrl_q <= ctrl_next;
        stat_q <= status_after(kind);
      end else if (wr_stat_hit) begin
        stat_q <= wdata[STAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cfgport_resp.sv
module cfgport_resp
  import cfgport_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_valid,
  input  logic     acc_write,
  input  cfg_sel_e sel,
  input  logic     bad,
  input  word_t    data_q,
  input  word_t    ctrl_q,
  input  stat_t    stat_q,
  output logic     rsp_valid,
  output word_t    rsp_rdata,
  output logic     rsp_err
);
  word_t rd_mux;

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = data_q;
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = widen_status(stat_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_err   <= bad;
      rsp_rdata <= (acc_valid && !acc_write && !bad) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter bit          PORT_EN = 1'b1,
  parameter logic [ADDR_W-1:0] OFS_DATA = 12'h0A0,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h0A4,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'h0A8,
  parameter int unsigned MASK_LO = 18,
  parameter int unsigned MASK_W  = 2,
  parameter logic [31:0] CODE_SHUTDOWN = 32'hC080_0000,
  parameter logic [31:0] CODE_REBOOT   = 32'hC090_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              shutdown_req,
  output logic              reboot_req
);
  // Named internal events, visible to the bound checker
  cfg_sel_e sel;
  logic     bad;
  logic     wr_data_hit, wr_ctrl_hit, wr_stat_hit;
  logic     cmd_off_hit, cmd_rbt_hit;
  word_t    data_q, ctrl_q;
  stat_t    stat_q;

  cfgport_decode #(
    .ADDR_W(ADDR_W), .PORT_EN(PORT_EN),
    .OFS_DATA(OFS_DATA), .OFS_CTRL(OFS_CTRL), .OFS_STAT(OFS_STAT)
  ) u_dec (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .sel        (sel),
    .bad        (bad),
    .wr_data_hit(wr_data_hit),
    .wr_ctrl_hit(wr_ctrl_hit),
    .wr_stat_hit(wr_stat_hit)
  );

  cfgport_cmd #(
    .MASK_LO(MASK_LO), .MASK_W(MASK_W),
    .CODE_SHUTDOWN(CODE_SHUTDOWN), .CODE_REBOOT(CODE_REBOOT)
  ) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_hit (wr_data_hit),
    .wr_ctrl_hit (wr_ctrl_hit),
    .wr_stat_hit (wr_stat_hit),
    .wdata       (acc_wdata),
    .data_q      (data_q),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q),
    .cmd_off_hit (cmd_off_hit),
    .cmd_rbt_hit (cmd_rbt_hit),
    .shutdown_req(shutdown_req),
    .reboot_req  (reboot_req)
  );

  cfgport_resp u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .sel      (sel),
    .bad      (bad),
    .data_q   (data_q),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .rsp_err  (rsp_err)
  );
endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk
  import cfgport_pkg::*;
#(
  parameter bit          PORT_EN = 1'b1,
  parameter int unsigned MASK_LO = 18,
  parameter int unsigned MASK_W  = 2
) (
  input logic  clk,
  input logic  rst_n,
  input logic  acc_valid,
  input logic  rsp_valid,
  input logic  rsp_err,
  input word_t rsp_rdata,
  input logic  shutdown_req,
  input logic  reboot_req,
  input logic  wr_ctrl_hit,
  input logic  cmd_off_hit,
  input logic  cmd_rbt_hit,
  input word_t ctrl_q,
  input stat_t stat_q
);
  assert_ctrl_field_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[MASK_LO +: MASK_W] == '0);

  assert_done_after_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl_hit |=> stat_q[0]);

  assert_shutdown_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_ctrl_hit && cmd_off_hit));

  assert_reboot_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |-> $past(wr_ctrl_hit && cmd_rbt_hit));

  assert_requests_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_req && reboot_req));

  assert_unknown_sets_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_hit && !cmd_off_hit && !cmd_rbt_hit) |=> (stat_q == 2'b11));

  assert_error_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  assert_absent_port_errors_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!PORT_EN && rsp_valid) |-> rsp_err);

  assert_response_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  assert_no_spurious_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
endmodule

bind cfgport_top cfgport_chk #(
  .PORT_EN(PORT_EN), .MASK_LO(MASK_LO), .MASK_W(MASK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .rsp_valid   (rsp_valid),
  .rsp_err     (rsp_err),
  .rsp_rdata   (rsp_rdata),
  .shutdown_req(shutdown_req),
  .reboot_req  (reboot_req),
  .wr_ctrl_hit (wr_ctrl_hit),
  .cmd_off_hit (cmd_off_hit),
  .cmd_rbt_hit (cmd_rbt_hit),
  .ctrl_q      (ctrl_q),
  .stat_q      (stat_q)
);

// File: tb/tb_cfgport_top.sv
module tb_cfgport_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;

  logic        rsp_valid, rsp_err, shutdown_req, reboot_req;
  logic [31:0] rsp_rdata;
  logic        o_rsp_valid, o_rsp_err, o_shutdown, o_reboot;
  logic [31:0] o_rsp_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_data, m_ctrl;
  logic [1:0]  m_stat;

  always #10 clk = ~clk;

  cfgport_top dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .shutdown_req(shutdown_req),
    .reboot_req(reboot_req)
  );

  cfgport_top #(.PORT_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rsp_valid(o_rsp_valid),
    .rsp_rdata(o_rsp_rdata), .rsp_err(o_rsp_err), .shutdown_req(o_shutdown),
    .reboot_req(o_reboot)
  );

  function automatic logic [31:0] exp_ctrl(input logic [31:0] v);
    return {v[31:20], 2'b00, v[17:0]};
  endfunction

  function automatic bit is_reg(input logic [11:0] a);
    return (a == 12'h0A0) || (a == 12'h0A4) || (a == 12'h0A8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; outputs are checked at the following falling edge
  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] e_rd;
    bit e_err, e_sd, e_rb;
    e_rd = 32'h0; e_err = !is_reg(a); e_sd = 1'b0; e_rb = 1'b0;
    if (!wr && !e_err) begin
      if (a == 12'h0A0) e_rd = m_data;
      else if (a == 12'h0A4) e_rd = m_ctrl;
      else e_rd = {30'h0, m_stat};
    end
    if (wr && !e_err) begin
      if (a == 12'h0A0) m_data = d;
      else if (a == 12'h0A8) m_stat = d[1:0];
      else begin
        m_ctrl = exp_ctrl(d);
        e_sd = (m_ctrl == 32'hC080_0000);
        e_rb = (m_ctrl == 32'hC090_0000);
        m_stat = (e_sd || e_rb) ? 2'b01 : 2'b11;
      end
    end
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h1);
    check(e_err ? "R9 err" : "R2/R3/R4 err", {31'h0, rsp_err}, {31'h0, e_err});
    check(e_err ? "R9 rdata" : "R2/R3/R4/R8 rdata", rsp_rdata, e_rd);
    check("R5 shutdown", {31'h0, shutdown_req}, {31'h0, e_sd});
    check("R6 reboot", {31'h0, reboot_req}, {31'h0, e_rb});
    check("R10 off err", {o_rsp_valid, o_rsp_err}, 32'h3);
    check("R10 off rdata", o_rsp_rdata, 32'h0);
    check("R10 off req", {o_shutdown, o_reboot}, 32'h0);
  endtask

  task automatic idle();
    acc_valid = 1'b0;
    @(negedge clk);
    check("R11 idle", {rsp_valid, shutdown_req, reboot_req}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_data = '0; m_ctrl = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 outputs", {rsp_valid, rsp_err, shutdown_req, reboot_req}, 32'h0);
    access(1'b0, 12'h0A0, 32'h0);
    access(1'b0, 12'h0A4, 32'h0);
    access(1'b0, 12'h0A8, 32'h0);
    idle();
    // R2 data round trip
    access(1'b1, 12'h0A0, 32'hDEAD_BEEF);
    access(1'b0, 12'h0A0, 32'h0);
    // R3 mask, R7 unknown code
    access(1'b1, 12'h0A4, 32'hFFFF_FFFF);
    access(1'b0, 12'h0A4, 32'h0);
    access(1'b0, 12'h0A8, 32'h0);
    // R8 clear status, upper bits dropped
    access(1'b1, 12'h0A8, 32'hFFFF_FFFC);
    access(1'b0, 12'h0A8, 32'h0);
    // R5 shutdown, single cycle
    access(1'b1, 12'h0A4, 32'hC080_0000);
    idle();
    access(1'b0, 12'h0A8, 32'h0);
    // R5 code reached only after masking bits 19:18
    access(1'b1, 12'h0A4, 32'hC08C_0000);
    // R6 reboot back to back with shutdown
    access(1'b1, 12'h0A4, 32'hC090_0000);
    access(1'b1, 12'h0A4, 32'hC094_0000);
    idle();
    // R9 near-miss addresses
    access(1'b1, 12'h0A1, 32'h1234_5678);
    access(1'b0, 12'h0AC, 32'h0);
    access(1'b0, 12'h0A0, 32'h0);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [11:0] a;
      logic [31:0] d;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2: a = 12'h0A0;
        3, 4, 5: a = 12'h0A4;
        6, 7:    a = 12'h0A8;
        default: a = 12'($urandom);
      endcase
      case ($urandom_range(0, 5))
        0: d = 32'hC080_0000 | ({30'h0, 2'($urandom)} << 18);
        1: d = 32'hC090_0000 | ({30'h0, 2'($urandom)} << 18);
        default: d = $urandom;
      endcase
      if ($urandom_range(0, 7) == 0) idle();
      access($urandom_range(0, 1) == 1, a, d);
    end
    idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule